// File: doc/BRIEF.md
# Store Buffer with Fence Sequencing

This block sits between a core's store port and the write port of an L1 data cache. Stores from the core are accepted into a small circular queue in program order and written to the cache later, one per cycle, oldest first, whenever the cache can take them. A load looks in the queue first. If a pending store to the same byte address is waiting there, the load takes the data of the youngest such store in the same cycle. Otherwise it is issued to the cache read port and counted as outstanding until the cache answers.

The core can also request three kinds of fence. A store fence holds back new stores until every queued store has been written to the cache. A load fence holds back new loads until no load is outstanding at the cache. A full fence does both. A fence reports completion with a one-cycle pulse, and only one fence may be pending at a time.

Top module: `stbuf_fence`

## Requirements
- R1: After reset the queue is empty and no load is outstanding: st_ready=1, ld_ready=1, fence_ready=1, wr_valid=0, fence_done=0.
- R2: The queue holds DEPTH (default 8) stores. A store is taken in a cycle with st_valid=1 and st_ready=1. st_ready is 0 whenever DEPTH stores are queued.
- R3: wr_valid is 1 exactly when the queue is non-empty. wr_addr/wr_data show the oldest queued store. One entry leaves per cycle with wr_valid=1 and wr_ready=1. While wr_ready is 0 the presented store stays unchanged.
- R4: A load accepted with the address of one or more queued stores gives ld_hit=1 in the same cycle, with ld_data from the youngest of them. A store accepted in the same cycle is not visible to that load. An entry that retires in that cycle is still visible.
- R5: An accepted load with no match raises cache_rd_valid in the same cycle, with cache_rd_addr=ld_addr and ld_hit=0. It stays outstanding until a cycle with ld_resp_valid=1. ld_ready is 0 while OUT_MAX (default 4) loads are outstanding.
- R6: fence_kind encodes 2'b01 store fence, 2'b10 load fence, 2'b11 full fence. A fence is taken when fence_valid=1 and fence_ready=1. fence_ready is 0 from the cycle after a fence is taken until its done pulse. Kind 2'b00 is taken but has no effect.
- R7: While a store fence or full fence is pending, st_ready is 0.
- R8: fence_done is 1 for exactly one cycle. It rises in the cycle after the first cycle in which the pending fence's conditions hold: the queue is empty for the store part, and zero loads are outstanding for the load part. The pending fence is released in that same cycle.
- R9: While a load fence or full fence is pending, ld_ready is 0.
- R10: A pending store fence does not stall loads, and a pending load fence does not stall stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request |
| st_addr | input | 8 | Store byte address |
| st_data | input | 32 | Store data |
| st_ready | output | 1 | Store can be taken |
| ld_valid | input | 1 | Load request |
| ld_addr | input | 8 | Load byte address |
| ld_ready | output | 1 | Load can be taken |
| ld_hit | output | 1 | Load served from the queue |
| ld_data | output | 32 | Forwarded load data |
| cache_rd_valid | output | 1 | Load issued to cache read port |
| cache_rd_addr | output | 8 | Cache read address |
| ld_resp_valid | input | 1 | Cache completed one outstanding load |
| wr_valid | output | 1 | Cache write request |
| wr_addr | output | 8 | Cache write address |
| wr_data | output | 32 | Cache write data |
| wr_ready | input | 1 | Cache accepts the write |
| fence_valid | input | 1 | Fence request |
| fence_kind | input | 2 | Fence kind |
| fence_ready | output | 1 | Fence can be taken |
| fence_done | output | 1 | One-cycle fence completion pulse |

## Verification
The hardest case to reach from the ports is a full fence whose two release conditions settle in different cycles. In that case the last queue write and the last cache load response come on separate edges, and the done pulse must follow whichever comes later. The bench sweeps every fence kind against zero to three queued stores, with two loads already outstanding. The fence arrives in the same cycle as a store and a load. The bench then toggles wr_ready and delays the load responses, so each condition finishes last in some runs. A reference queue in the bench predicts every handshake, forwarded value and write in every cycle.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        FK_NONE  = 2'b00,
        FK_STORE = 2'b01,
        FK_LOAD  = 2'b10,
        FK_FULL  = 2'b11
    } fence_kind_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } sb_entry_t;

    function automatic logic kind_orders_stores(input logic [1:0] k);
        return k[0];
    endfunction

    function automatic logic kind_orders_loads(input logic [1:0] k);
        return k[1];
    endfunction

endpackage

// File: rtl/stbuf_queue.sv
module stbuf_queue
    import stbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output sb_entry_t         ents [DEPTH],
    output logic [PW-1:0]     head,
    output logic [CW-1:0]     occ
);

    logic [PW-1:0] tail;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                ents[i] <= '0;
            end
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else begin
            if (push) begin
                ents[tail] <= '{valid: 1'b1, addr: push_addr, data: push_data};
                tail       <= tail + 1'b1;
            end
            if (pop) begin
                ents[head].valid <= 1'b0;
                head             <= head + 1'b1;
            end
            occ <= occ + CW'(push) - CW'(pop);
        end
    end

endmodule

// File: rtl/stbuf_fwd.sv
module stbuf_fwd
    import stbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  sb_entry_t         ents [DEPTH],
    input  logic [PW-1:0]     head,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data
);

    logic [PW-1:0] slot;

    // Walk from oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        slot     = '0;
        for (int i = 0; i < DEPTH; i++) begin
            slot = head + PW'(i);
            if (ents[slot].valid && ents[slot].addr == look_addr) begin
                hit      = 1'b1;
                hit_data = ents[slot].data;
            end
        end
    end

endmodule

// File: rtl/stbuf_fence_ctl.sv
module stbuf_fence_ctl
    import stbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fence_valid,
    input  logic [1:0] fence_kind,
    input  logic       queue_empty,
    input  logic       loads_idle,
    output logic       fence_ready,
    output logic       pend_st,
    output logic       pend_ld,
    output logic       fence_done
);

    logic [1:0] pend_kind;
    logic       release_now;

    assign fence_ready = (pend_kind == FK_NONE);
    assign pend_st     = kind_orders_stores(pend_kind);
    assign pend_ld     = kind_orders_loads(pend_kind);
    assign release_now = !fence_ready
                         && (!pend_st || queue_empty)
                         && (!pend_ld || loads_idle);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_kind  <= FK_NONE;
            fence_done <= 1'b0;
        end else begin
            fence_done <= release_now;
            if (release_now) begin
                pend_kind <= FK_NONE;
            end
            if (fence_valid && fence_ready) begin
                pend_kind <= fence_kind;
            end
        end
    end

endmodule

// File: rtl/stbuf_fence.sv
module stbuf_fence
    import stbuf_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int OUT_MAX = 4,
    localparam int PW  = $clog2(DEPTH),
    localparam int CW  = $clog2(DEPTH + 1),
    localparam int OW  = $clog2(OUT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_ready,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_ready,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    output logic              cache_rd_valid,
    output logic [ADDR_W-1:0] cache_rd_addr,
    input  logic              ld_resp_valid,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready,
    input  logic              fence_valid,
    input  logic [1:0]        fence_kind,
    output logic              fence_ready,
    output logic              fence_done
);

    sb_entry_t         ents [DEPTH];
    logic [PW-1:0]     head;
    logic [CW-1:0]     occ;
    logic [OW-1:0]     outs;
    logic              pend_st;
    logic              pend_ld;
    logic              push;
    logic              pop;
    logic              ld_go;
    logic              fwd_hit;
    logic [DATA_W-1:0] fwd_data;
    logic              resp_ok;

    assign st_ready = (occ != CW'(DEPTH)) && !pend_st;
    assign push     = st_valid && st_ready;

    assign wr_valid = ents[head].valid;
    assign wr_addr  = ents[head].addr;
    assign wr_data  = ents[head].data;
    assign pop      = wr_valid && wr_ready;

    stbuf_queue #(.DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_addr (st_addr),
        .push_data (st_data),
        .pop       (pop),
        .ents      (ents),
        .head      (head),
        .occ       (occ)
    );

    stbuf_fwd #(.DEPTH(DEPTH)) u_fwd (
        .ents      (ents),
        .head      (head),
        .look_addr (ld_addr),
        .hit       (fwd_hit),
        .hit_data  (fwd_data)
    );

    assign ld_ready       = !pend_ld && (outs != OW'(OUT_MAX));
    assign ld_go          = ld_valid && ld_ready;
    assign ld_hit         = ld_go && fwd_hit;
    assign ld_data        = fwd_data;
    assign cache_rd_valid = ld_go && !fwd_hit;
    assign cache_rd_addr  = ld_addr;
    assign resp_ok        = ld_resp_valid && (outs != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            outs <= '0;
        end else begin
            outs <= outs + OW'(cache_rd_valid) - OW'(resp_ok);
        end
    end

    stbuf_fence_ctl u_fctl (
        .clk         (clk),
        .rst         (rst),
        .fence_valid (fence_valid),
        .fence_kind  (fence_kind),
        .queue_empty (occ == '0),
        .loads_idle  (outs == '0),
        .fence_ready (fence_ready),
        .pend_st     (pend_st),
        .pend_ld     (pend_ld),
        .fence_done  (fence_done)
    );

endmodule

// File: rtl/stbuf_fence_chk.sv
module stbuf_fence_chk
    import stbuf_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int OUT_MAX = 4,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int OW = $clog2(OUT_MAX + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              st_ready,
    input logic              ld_ready,
    input logic              ld_hit,
    input logic              cache_rd_valid,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              fence_done,
    input logic [CW-1:0]     occ,
    input logic [OW-1:0]     outs,
    input logic              pend_st,
    input logic              pend_ld
);

    assert_full_blocks_R2: assert property (@(posedge clk) disable iff (rst)
        occ == CW'(DEPTH) |-> !st_ready);

    assert_empty_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        occ == '0 |-> !wr_valid);

    assert_write_held_R3: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    assert_hit_or_miss_R5: assert property (@(posedge clk) disable iff (rst)
        !(ld_hit && cache_rd_valid));

    assert_out_limit_R5: assert property (@(posedge clk) disable iff (rst)
        outs == OW'(OUT_MAX) |-> !ld_ready);

    assert_store_stall_R7: assert property (@(posedge clk) disable iff (rst)
        pend_st |-> !st_ready);

    assert_done_cond_R8: assert property (@(posedge clk) disable iff (rst)
        fence_done |-> $past((!pend_st || occ == '0) && (!pend_ld || outs == '0)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        fence_done |=> !fence_done);

    assert_load_stall_R9: assert property (@(posedge clk) disable iff (rst)
        pend_ld |-> !ld_ready);

endmodule

bind stbuf_fence stbuf_fence_chk #(.DEPTH(DEPTH), .OUT_MAX(OUT_MAX)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .st_ready       (st_ready),
    .ld_ready       (ld_ready),
    .ld_hit         (ld_hit),
    .cache_rd_valid (cache_rd_valid),
    .wr_valid       (wr_valid),
    .wr_ready       (wr_ready),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .fence_done     (fence_done),
    .occ            (occ),
    .outs           (outs),
    .pend_st        (pend_st),
    .pend_ld        (pend_ld)
);

// File: tb/stbuf_fence_test.sv
module stbuf_fence_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int OUT_MAX    = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        st_valid, ld_valid, ld_resp_valid, wr_ready, fence_valid;
    logic [7:0]  st_addr, ld_addr;
    logic [31:0] st_data;
    logic [1:0]  fence_kind;
    logic        st_ready, ld_ready, ld_hit, cache_rd_valid, wr_valid, fence_ready, fence_done;
    logic [31:0] ld_data, wr_data;
    logic [7:0]  cache_rd_addr, wr_addr;

    int nchk = 0;
    int nfail = 0;

    logic [7:0]  mq_a [$];
    logic [31:0] mq_d [$];
    int          m_out = 0;
    logic [1:0]  m_pend = 2'b00;
    logic        m_done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stbuf_fence #(.DEPTH(DEPTH), .OUT_MAX(OUT_MAX)) uut (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_ready(ld_ready), .ld_hit(ld_hit),
        .ld_data(ld_data), .cache_rd_valid(cache_rd_valid), .cache_rd_addr(cache_rd_addr),
        .ld_resp_valid(ld_resp_valid), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ready(wr_ready), .fence_valid(fence_valid),
        .fence_kind(fence_kind), .fence_ready(fence_ready), .fence_done(fence_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    // One cycle: check outputs against the reference model, then advance it.
    task automatic cyc();
        bit    e_st, e_ld, e_hit, e_fr, go_ld, rel, tk_st, tk_pop;
        logic [31:0] e_data;
        #1;
        e_st = (mq_a.size() < DEPTH) && !m_pend[0];
        chk(st_ready == e_st, m_pend[0] ? "R7 st_ready" : (m_pend[1] ? "R10 st_ready" : "R2 st_ready"),
            32'(st_ready), 32'(e_st));
        chk(wr_valid == (mq_a.size() > 0), "R3 wr_valid", 32'(wr_valid), 32'(mq_a.size() > 0));
        if (mq_a.size() > 0) begin
            chk(wr_addr == mq_a[0], "R3 wr_addr", 32'(wr_addr), 32'(mq_a[0]));
            chk(wr_data == mq_d[0], "R3 wr_data", wr_data, mq_d[0]);
        end
        e_ld = !m_pend[1] && (m_out < OUT_MAX);
        chk(ld_ready == e_ld, m_pend[1] ? "R9 ld_ready" : (m_pend[0] ? "R10 ld_ready" : "R5 ld_ready"),
            32'(ld_ready), 32'(e_ld));
        e_hit = 1'b0;
        e_data = '0;
        for (int i = mq_a.size() - 1; i >= 0; i--) begin
            if (!e_hit && mq_a[i] == ld_addr) begin
                e_hit = 1'b1;
                e_data = mq_d[i];
            end
        end
        go_ld = ld_valid && e_ld;
        if (go_ld) begin
            chk(ld_hit == e_hit, "R4 ld_hit", 32'(ld_hit), 32'(e_hit));
            if (e_hit) chk(ld_data == e_data, "R4 ld_data", ld_data, e_data);
            chk(cache_rd_valid == !e_hit, "R5 cache_rd_valid", 32'(cache_rd_valid), 32'(!e_hit));
            if (!e_hit) chk(cache_rd_addr == ld_addr, "R5 cache_rd_addr", 32'(cache_rd_addr), 32'(ld_addr));
        end else begin
            chk(!ld_hit && !cache_rd_valid, "R5 idle load", {ld_hit, cache_rd_valid}, 0);
        end
        e_fr = (m_pend == 2'b00);
        chk(fence_ready == e_fr, "R6 fence_ready", 32'(fence_ready), 32'(e_fr));
        chk(fence_done == m_done, "R8 fence_done", 32'(fence_done), 32'(m_done));
        rel = (m_pend != 2'b00) && (!m_pend[0] || mq_a.size() == 0) && (!m_pend[1] || m_out == 0);
        tk_st = st_valid && e_st;
        tk_pop = wr_ready && (mq_a.size() > 0);
        @(posedge clk);
        m_done = rel;
        if (rel) m_pend = 2'b00;
        if (fence_valid && e_fr) m_pend = fence_kind;
        if (tk_pop) begin
            void'(mq_a.pop_front());
            void'(mq_d.pop_front());
        end
        if (tk_st) begin
            mq_a.push_back(st_addr);
            mq_d.push_back(st_data);
        end
        if (go_ld && !e_hit) m_out++;
        if (ld_resp_valid && m_out > 0) m_out--;
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        st_valid = 0; ld_valid = 0; ld_resp_valid = 0; wr_ready = 0; fence_valid = 0;
        st_addr = 0; st_data = 0; ld_addr = 0; fence_kind = 2'b00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        #1;
        chk(st_ready && ld_ready && fence_ready && !wr_valid && !fence_done, "R1 reset outputs",
            {st_ready, ld_ready, fence_ready, wr_valid, fence_done}, 5'b11100);
        @(negedge clk);

        // R2/R4: fill past capacity with repeated addresses while the cache is stalled
        for (int k = 0; k < 12; k++) begin
            st_valid = 1; st_addr = 8'((k % 3) * 4); st_data = 32'hA000 + 32'(k);
            cyc();
        end
        st_valid = 0;
        // R4/R5: sweep every low address; hits take the youngest copy, others miss
        for (int k = 0; k < 16; k++) begin
            ld_valid = 1; ld_addr = 8'(k);
            ld_resp_valid = (m_out > 0) && (k % 3 == 0);
            cyc();
        end
        ld_valid = 0;
        // R3/R4: drain with an irregular cache ready while loads keep probing
        for (int k = 0; k < 30; k++) begin
            wr_ready = (k % 3) != 1;
            ld_valid = 1; ld_addr = 8'((k % 4) * 4);
            ld_resp_valid = (m_out > 0);
            st_valid = (k % 5 == 0); st_addr = 8'(k); st_data = 32'hB000 + 32'(k);
            cyc();
        end
        idle_inputs();
        while (mq_a.size() > 0 || m_out > 0) begin
            wr_ready = 1; ld_resp_valid = (m_out > 0);
            cyc();
        end
        idle_inputs();
        cyc();

        // R6-R10: every fence kind against zero to three queued stores
        for (int kind = 0; kind < 4; kind++) begin
            for (int ns = 0; ns < 4; ns++) begin
                for (int j = 0; j < ns; j++) begin
                    st_valid = 1; st_addr = 8'(16 + j); st_data = 32'hC000 + 32'(kind * 16 + j);
                    cyc();
                end
                st_valid = 0;
                for (int j = 0; j < 2; j++) begin
                    ld_valid = 1; ld_addr = 8'h80 + 8'(j);
                    cyc();
                end
                // fence in the same cycle as a store and a load (both count as older)
                fence_valid = 1; fence_kind = 2'(kind);
                st_valid = 1; st_addr = 8'h30; st_data = 32'hD000 + 32'(kind * 4 + ns);
                ld_valid = 1; ld_addr = 8'h90;
                cyc();
                fence_valid = 0;
                for (int c = 0; c < 16; c++) begin
                    st_valid = 1; st_addr = 8'h40 + 8'(c); st_data = 32'hE000 + 32'(c);
                    ld_valid = 1; ld_addr = (c % 2 == 0) ? 8'h30 : 8'hA0 + 8'(c);
                    wr_ready = (c % 2) == (ns % 2);
                    ld_resp_valid = (m_out > 0) && (c >= 2 + kind);
                    cyc();
                end
                idle_inputs();
                while (mq_a.size() > 0 || m_out > 0 || m_pend != 2'b00) begin
                    wr_ready = 1; ld_resp_valid = (m_out > 0);
                    cyc();
                end
                idle_inputs();
                cyc();
                cyc();
            end
        end
        summary();
    end

endmodule